// File: doc/BRIEF.md
# Programmable Word-State Transition Table

This block decides what happens to the monitoring state of a memory word each time the word is touched. Every lookup presents the current state of the accessed word together with an event code. The event can be a load, a store, or a software-defined event that only moves the state and never touches data. One cycle later the block returns the next state to write back and a flag that marks the access as a violation. The decision comes from a small table that software fills at run time. Different checkers, such as a heap checker or a return-address checker, can therefore be loaded into the same hardware.

The table has one entry for every pair of state and event. Each entry holds a next state and an exception bit. A write port loads one entry at a time. Because lookups stream in at one per cycle, a write that arrives in the same cycle as a lookup is refused, and the writer retries. This means a lookup never sees a half-updated table. After reset every entry keeps the state unchanged and raises no exception, so the checker has no effect until it is programmed.

Top module: `tag_transition_table`

## Requirements
- R1: After reset, `res_valid`, `res_next_state` and `res_exc` are 0.
- R2: Before any write, a lookup of every (state, event) pair returns next state equal to the presented state, with `res_exc` = 0.
- R3: `res_valid` is high in the cycle after a cycle with `lk_valid` high, and low otherwise. Lookups may be presented on every cycle.
- R4: The result of a lookup is the entry at index {state, event}, with the state in the upper bits. `res_next_state` is the entry's next-state field, and `res_exc` is its exception bit. The next state is reported even when the exception bit is 1.
- R5: `wr_ack` is 1 exactly when `wr_req` is 1 and `lk_valid` is 0. An acknowledged write is visible to a lookup presented in the next cycle.
- R6: A write presented while `lk_valid` is 1 gets `wr_ack` = 0 and leaves the table unchanged.
- R7: While `res_valid` is 0, `res_next_state` and `res_exc` are 0.
- R8: A write changes only the entry it addresses.
- R9: The table can be loaded as a heap checker and then behaves as one. State codes: 0 non-heap, 1 unallocated, 2 allocated but unwritten, 3 written. Event codes: 0 allocate, 1 free, 2 load, 3 store. Allowed moves: a non-heap word keeps state 0 on a load or store. Allocate takes state 1 to 2. A store takes state 2 to 3. A free takes state 2 or 3 to 1. A load or store keeps state 3. Every other combination flags an exception and keeps the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_state | input | STATE_W | Current state of the accessed word |
| lk_event | input | EVENT_W | Event code |
| wr_req | input | 1 | Table write request |
| wr_state | input | STATE_W | State part of the entry index |
| wr_event | input | EVENT_W | Event part of the entry index |
| wr_next | input | STATE_W | Next state to store |
| wr_exc | input | 1 | Exception bit to store |
| wr_ack | output | 1 | Write accepted this cycle |
| res_valid | output | 1 | Lookup result valid |
| res_next_state | output | STATE_W | Next state for the word |
| res_exc | output | 1 | Exception flag |

## Verification
The hardest case to reach from the ports is a write colliding with a lookup. The refused write must leave no trace, and that can only be seen by a later lookup of the exact entry it targeted. The random phase raises `wr_req` and `lk_valid` independently on most cycles, so collisions are frequent. The reference table in the bench updates only on writes it expects to be accepted, and that table is then probed by later random lookups. A directed phase loads the heap checker and walks through every state and event pair, including those that raise an exception.

// File: rtl/tag_transition_table.sv
module tag_transition_table #(
  parameter int STATE_W = 4,
  parameter int EVENT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [STATE_W-1:0] lk_state,
  input  logic [EVENT_W-1:0] lk_event,
  input  logic               wr_req,
  input  logic [STATE_W-1:0] wr_state,
  input  logic [EVENT_W-1:0] wr_event,
  input  logic [STATE_W-1:0] wr_next,
  input  logic               wr_exc,
  output logic               wr_ack,
  output logic               res_valid,
  output logic [STATE_W-1:0] res_next_state,
  output logic               res_exc
);
  localparam int IW    = STATE_W + EVENT_W;
  localparam int DEPTH = 1 << IW;
  localparam int ENT_W = STATE_W + 1;

  logic [ENT_W-1:0] tbl [DEPTH];
  logic [ENT_W-1:0] res_q;
  logic             valid_q;
  logic [IW-1:0]    lk_idx, wr_idx;

  assign lk_idx = {lk_state, lk_event};
  assign wr_idx = {wr_state, wr_event};
  assign wr_ack = wr_req & ~lk_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        tbl[i] <= {STATE_W'(i >> EVENT_W), 1'b0};
    end else if (wr_ack) begin
      tbl[wr_idx] <= {wr_next, wr_exc};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= lk_valid;
      res_q   <= lk_valid ? tbl[lk_idx] : '0;
    end
  end

  assign res_valid      = valid_q;
  assign res_next_state = res_q[ENT_W-1:1];
  assign res_exc        = res_q[0];

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_next_state == '0 && !res_exc));
  a_r6_no_ack_in_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> !wr_ack);
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> tbl[$past(wr_idx)] == $past({wr_next, wr_exc}));
  a_r4_result_from_entry: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> {res_next_state, res_exc} == $past(tbl[lk_idx]));
endmodule

// File: tb/tag_transition_table_test.sv
module tag_transition_table_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 4;
  localparam int EW = 3;
  localparam int DEPTH = 1 << (SW + EW);

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, wr_req = 0, wr_exc = 0;
  logic [SW-1:0] lk_state = 0, wr_state = 0, wr_next = 0;
  logic [EW-1:0] lk_event = 0, wr_event = 0;
  logic wr_ack, res_valid, res_exc;
  logic [SW-1:0] res_next_state;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [SW:0] model [DEPTH];

  tag_transition_table #(.STATE_W(SW), .EVENT_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_state(lk_state),
    .lk_event(lk_event), .wr_req(wr_req), .wr_state(wr_state),
    .wr_event(wr_event), .wr_next(wr_next), .wr_exc(wr_exc),
    .wr_ack(wr_ack), .res_valid(res_valid), .res_next_state(res_next_state),
    .res_exc(res_exc));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [SW:0] heap_ent(int s, int e);
    case (s)
      0: return (e >= 2) ? {4'd0, 1'b0} : {4'd0, 1'b1};
      1: return (e == 0) ? {4'd2, 1'b0} : {4'd1, 1'b1};
      2: case (e)
           1: return {4'd1, 1'b0};
           3: return {4'd3, 1'b0};
           default: return {4'd2, 1'b1};
         endcase
      default: return (e == 0) ? {4'd3, 1'b1} : (e == 1) ? {4'd1, 1'b0} : {4'd3, 1'b0};
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic lv, logic [SW-1:0] ls, logic [EW-1:0] le,
                      logic wq, logic [SW-1:0] ws, logic [EW-1:0] we,
                      logic [SW-1:0] wn, logic wx);
    logic [SW:0] exp_res;
    lk_valid = lv; lk_state = ls; lk_event = le;
    wr_req = wq; wr_state = ws; wr_event = we; wr_next = wn; wr_exc = wx;
    #1;
    check(lv ? "R6 ack" : "R5 ack", {31'd0, wr_ack}, {31'd0, wq & ~lv});
    exp_res = lv ? model[{ls, le}] : '0;
    if (wq && !lv) model[{ws, we}] = {wn, wx};
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0; wr_req = 0;
    check({req, " R3 valid"}, {31'd0, res_valid}, {31'd0, lv});
    check(lv ? {req, " R4 result"} : "R7 idle", {27'd0, res_next_state, res_exc},
          {27'd0, exp_res});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) model[i] = {SW'(i >> EW), 1'b0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid", {31'd0, res_valid}, 0);
    check("R1 result", {27'd0, res_next_state, res_exc}, 0);
    rst_n = 1;

    for (int i = 0; i < DEPTH; i++)
      step("R2", 1, SW'(i >> EW), EW'(i), 0, 0, 0, 0, 0);

    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 4; e++) begin
        logic [SW:0] h;
        h = heap_ent(s, e);
        step("R9 load", 0, 0, 0, 1, SW'(s), EW'(e), h[SW:1], h[0]);
      end
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 4; e++)
        step("R9", 1, SW'(s), EW'(e), 0, 0, 0, 0, 0);

    step("R5 write", 0, 0, 0, 1, 4'd7, 3'd5, 4'd9, 1'b1);
    step("R5 next", 1, 4'd7, 3'd5, 0, 0, 0, 0, 0);
    step("R6 refused", 1, 4'd2, 3'd2, 1, 4'd7, 3'd5, 4'd1, 1'b0);
    step("R6 unchanged", 1, 4'd7, 3'd5, 0, 0, 0, 0, 0);
    step("R8 neighbour", 1, 4'd7, 3'd4, 0, 0, 0, 0, 0);

    for (int n = 0; n < 4000; n++)
      step("R8 random", 1'($urandom_range(0, 1)), SW'($urandom), EW'($urandom),
           1'($urandom_range(0, 1)), SW'($urandom), EW'($urandom),
           SW'($urandom), 1'($urandom));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule